// File: doc/BRIEF.md
# Seeded Word-Serial CRC-32 Accumulator

This block keeps a 32-bit running CRC remainder for hashing and index generation. Software first loads the remainder with any 32-bit seed. It then folds data words into the remainder one accumulate request at a time. Each request carries a byte-lane mask, so only part of a word can take part. When the words are done, the remainder is read back, for example as a cache or table index.

Each accumulate operation has a fixed multi-cycle latency. While an operation is running, `busy` is high, and the block refuses new accumulate requests and seed writes. A read asked for while an operation is running is held. It is answered in the cycle the operation retires, with the updated remainder.

The generator polynomial is 0x04C11DB7. Data is taken most significant bit first, with no bit reflection, and no output inversion is applied.

Top module: `crc_word_accum`

## Requirements
- R1: After reset the remainder holds 0xFFFFFFFF, `busy` is low and `rd_valid` is low.
- R2: A seed write (`seed_we` high while `busy` is low) replaces the remainder with `seed_data` from the next cycle. If an accumulate request arrives in the same cycle, the seed write wins and the request is refused.
- R3: An accumulate folds the selected bytes into the remainder with polynomial 0x04C11DB7, most significant bit first, with no reflection and no final inversion. With seed 0xFFFFFFFF, the bytes of the ASCII string "123456789" give 0x0376E6E7.
- R4: Bit 3 of `acc_be` selects `acc_data[31:24]`, bit 2 selects `[23:16]`, bit 1 selects `[15:8]` and bit 0 selects `[7:0]`. The selected bytes are folded from the most significant lane down to the least significant lane. Unselected lanes are skipped. A mask of 0 leaves the remainder unchanged.
- R5: An accepted accumulate holds `busy` high for exactly LATENCY cycles (default 14). The new remainder takes effect on the edge where `busy` drops.
- R6: An accumulate request made while `busy` is high is refused and has no effect on the remainder.
- R7: A seed write made while `busy` is high is refused and has no effect on the remainder.
- R8: A read (`rd_req`) made with no operation running or starting gives a one-cycle `rd_valid` pulse on the next cycle. `rd_data` then carries the remainder, including any seed written in the same cycle.
- R9: A read made while `busy` is high, or in the same cycle as an accepted accumulate, is held. It is answered with the updated remainder in the first cycle that `busy` is low. `rd_valid` is never high while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seed_we | input | 1 | Seed write strobe |
| seed_data | input | 32 | Seed value |
| acc_req | input | 1 | Accumulate request |
| acc_data | input | 32 | Word to fold in |
| acc_be | input | 4 | Byte-lane select, bit n selects byte n |
| rd_req | input | 1 | Remainder read request |
| busy | output | 1 | Accumulate operation in progress |
| rd_valid | output | 1 | Read answer strobe |
| rd_data | output | 32 | Remainder returned by a read |

## Verification
The bench goes after the following corner cases:
- **Lane order.** It checks the ASCII check string split across three words, with a partial mask on the last word. A design that folds lanes in the wrong order, or that shifts zeros through skipped lanes, returns a different value.
- **Busy window.** It counts the `busy` cycles directly, so an off-by-one in the latency counter shows up as 13 or 15.
- **Requests while busy.** It sends accumulate requests and seed writes during the busy window. A design that lets either one through would corrupt the remainder it later reads back.
- **Held read.** It issues a read mid-operation. A design that answered at once would return the stale remainder and would raise `rd_valid` while `busy` is still high.

// File: rtl/crc_accum_pkg.sv
package crc_accum_pkg;
   localparam int CRC_W = 32;

   function automatic logic [CRC_W-1:0] crc_byte_step(
      input logic [CRC_W-1:0] rem,
      input logic [7:0]       din,
      input logic [CRC_W-1:0] poly
   );
      logic [CRC_W-1:0] r;
      logic             fb;
      r = rem;
      for (int b = 7; b >= 0; b--) begin
         fb = r[CRC_W-1] ^ din[b];
         r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
      end
      return r;
   endfunction
endpackage

// File: rtl/crc_lane_fold.sv
module crc_lane_fold
   import crc_accum_pkg::*;
#(
   parameter int               LANES = 4,
   parameter logic [CRC_W-1:0] POLY  = 32'h04C1_1DB7
) (
   input  logic [CRC_W-1:0]   rem_in,
   input  logic [8*LANES-1:0] word_in,
   input  logic [LANES-1:0]   lane_en,
   output logic [CRC_W-1:0]   rem_out
);
   logic [CRC_W-1:0] stage [LANES+1];

   assign stage[LANES] = rem_in;

   for (genvar ln = LANES - 1; ln >= 0; ln--) begin : g_lane
      logic [CRC_W-1:0] stepped;
      assign stepped   = crc_byte_step(stage[ln+1], word_in[8*ln +: 8], POLY);
      assign stage[ln] = lane_en[ln] ? stepped : stage[ln+1];
   end

   assign rem_out = stage[0];
endmodule

// File: rtl/crc_op_timer.sv
module crc_op_timer #(
   parameter int LATENCY = 14
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);
   initial begin
      if (LATENCY < 1) $error("crc_op_timer: LATENCY must be at least 1");
   end

   if (LATENCY == 1) begin : g_single
      logic run_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      run_q <= 1'b0;
         else if (run_q)  run_q <= 1'b0;
         else if (start)  run_q <= 1'b1;
      end
      assign busy = run_q;
      assign done = run_q;
   end else begin : g_count
      localparam int CNT_W = $clog2(LATENCY + 1);
      localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LATENCY);
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              cnt_q <= '0;
         else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
         else if (start)          cnt_q <= CNT_LOAD;
      end
      assign busy = (cnt_q != '0);
      assign done = (cnt_q == CNT_W'(1));
   end
endmodule

// File: rtl/crc_word_accum.sv
module crc_word_accum
   import crc_accum_pkg::*;
#(
   parameter int               LANES   = 4,
   parameter int               LATENCY = 14,
   parameter logic [CRC_W-1:0] POLY    = 32'h04C1_1DB7,
   parameter logic [CRC_W-1:0] RST_REM = 32'hFFFF_FFFF
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 seed_we,
   input  logic [CRC_W-1:0]     seed_data,
   input  logic                 acc_req,
   input  logic [8*LANES-1:0]   acc_data,
   input  logic [LANES-1:0]     acc_be,
   input  logic                 rd_req,
   output logic                 busy,
   output logic                 rd_valid,
   output logic [CRC_W-1:0]     rd_data
);
   initial begin
      if (LANES < 1)       $error("crc_word_accum: LANES must be at least 1");
      if (8 * LANES > 64)  $error("crc_word_accum: at most 8 lanes");
      if (LATENCY < 1)     $error("crc_word_accum: LATENCY must be at least 1");
   end

   logic [CRC_W-1:0] rem_q;
   logic [CRC_W-1:0] pend_q;
   logic [CRC_W-1:0] fold_val;
   logic             rd_hold_q;
   logic             op_done;
   logic             seed_take;
   logic             acc_take;

   assign seed_take = seed_we & ~busy;
   assign acc_take  = acc_req & ~busy & ~seed_we;

   crc_lane_fold #(.LANES(LANES), .POLY(POLY)) u_fold (
      .rem_in  (rem_q),
      .word_in (acc_data),
      .lane_en (acc_be),
      .rem_out (fold_val)
   );

   crc_op_timer #(.LATENCY(LATENCY)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (acc_take),
      .busy  (busy),
      .done  (op_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= RST_REM;
         pend_q <= '0;
      end else begin
         if (seed_take)     rem_q <= seed_data;
         else if (op_done)  rem_q <= pend_q;
         if (acc_take)      pend_q <= fold_val;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid  <= 1'b0;
         rd_data   <= '0;
         rd_hold_q <= 1'b0;
      end else begin
         rd_valid <= 1'b0;
         if (op_done) begin
            rd_hold_q <= 1'b0;
            if (rd_hold_q | rd_req) begin
               rd_valid <= 1'b1;
               rd_data  <= pend_q;
            end
         end else if (rd_req & (busy | acc_take)) begin
            rd_hold_q <= 1'b1;
         end else if (rd_req) begin
            rd_valid <= 1'b1;
            rd_data  <= seed_take ? seed_data : rem_q;
         end
      end
   end
endmodule

// File: rtl/crc_word_accum_chk.sv
module crc_word_accum_chk #(
   parameter int LATENCY = 14
) (
   input logic clk,
   input logic rst_n,
   input logic seed_we,
   input logic acc_req,
   input logic rd_req,
   input logic busy,
   input logic rd_valid
);
   logic [15:0] busy_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     busy_len <= '0;
      else if (busy)  busy_len <= busy_len + 1'b1;
      else            busy_len <= '0;
   end

   // R5
   acc_starts_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_req && !busy && !seed_we) |=> busy);

   // R5
   busy_window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (busy_len == 16'(LATENCY)));

   // R2
   busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(acc_req) && !$past(seed_we)));

   // R9
   no_answer_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> !busy);

   // R8
   idle_read_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !busy && !(acc_req && !seed_we)) |=> rd_valid);
endmodule

bind crc_word_accum crc_word_accum_chk #(.LATENCY(LATENCY)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .seed_we  (seed_we),
   .acc_req  (acc_req),
   .rd_req   (rd_req),
   .busy     (busy),
   .rd_valid (rd_valid)
);

// File: tb/crc_word_accum_bench.sv
module crc_word_accum_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        seed_we = 1'b0;
   logic [31:0] seed_data = '0;
   logic        acc_req = 1'b0;
   logic [31:0] acc_data = '0;
   logic [3:0]  acc_be = '0;
   logic        rd_req = 1'b0;
   logic        busy;
   logic        rd_valid;
   logic [31:0] rd_data;

   int n_run  = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   crc_word_accum u_crc_word_accum (
      .clk(clk), .rst_n(rst_n), .seed_we(seed_we), .seed_data(seed_data),
      .acc_req(acc_req), .acc_data(acc_data), .acc_be(acc_be),
      .rd_req(rd_req), .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data)
   );

   // {seed, data, lane mask}
   localparam logic [67:0] VEC [8] = '{
      {32'hFFFF_FFFF, 32'h3132_3334, 4'hF},
      {32'h0000_0000, 32'h0000_0001, 4'hF},
      {32'h1234_5678, 32'hDEAD_BEEF, 4'h8},
      {32'h1234_5678, 32'hDEAD_BEEF, 4'h1},
      {32'hA5A5_5A5A, 32'h0102_0304, 4'h5},
      {32'h4242_4242, 32'hC0A8_0001, 4'hA},
      {32'h8000_0000, 32'hFFFF_FFFF, 4'h6},
      {32'hCAFE_F00D, 32'h7777_7777, 4'h0}
   };

   function automatic logic [31:0] ref_crc(logic [31:0] r, logic [31:0] d, logic [3:0] be);
      logic fb;
      for (int k = 31; k >= 0; k--) begin
         if (be[k/8]) begin
            fb = r[31] ^ d[k];
            r  = r << 1;
            if (fb) r = r ^ 32'h04C1_1DB7;
         end
      end
      return r;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_seed(logic [31:0] v);
      @(negedge clk); seed_we = 1'b1; seed_data = v;
      @(negedge clk); seed_we = 1'b0;
   endtask

   task automatic issue_acc(logic [31:0] d, logic [3:0] be);
      @(negedge clk); acc_req = 1'b1; acc_data = d; acc_be = be;
      @(negedge clk); acc_req = 1'b0;
   endtask

   task automatic wait_idle();
      int guard = 0;
      while (busy && guard < 1000) begin @(negedge clk); guard++; end
   endtask

   task automatic do_read(output logic [31:0] v, output logic ok);
      @(negedge clk); rd_req = 1'b1;
      @(negedge clk); rd_req = 1'b0;
      ok = rd_valid; v = rd_data;
   endtask

   initial begin
      #400000;
      if (!finished) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      logic        ok;
      logic [31:0] exp;
      int          n;

      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 busy", {31'd0, busy}, 32'd0);
      check("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
      rst_n = 1'b1;
      do_read(v, ok);
      check("R1 reset remainder", v, 32'hFFFF_FFFF);
      check("R8 idle read valid", {31'd0, ok}, 32'd1);

      // R3 R4 table walk
      for (int i = 0; i < 8; i++) begin
         do_seed(VEC[i][67:36]);
         issue_acc(VEC[i][35:4], VEC[i][3:0]);
         wait_idle();
         do_read(v, ok);
         check($sformatf("R3/R4 vector %0d", i), v,
               ref_crc(VEC[i][67:36], VEC[i][35:4], VEC[i][3:0]));
      end

      // R3 check string over three words, partial last word (R4)
      do_seed(32'hFFFF_FFFF);
      issue_acc(32'h3132_3334, 4'hF); wait_idle();
      issue_acc(32'h3536_3738, 4'hF); wait_idle();
      issue_acc(32'h3900_0000, 4'h8); wait_idle();
      do_read(v, ok);
      check("R3 check string", v, 32'h0376_E6E7);

      // R4 mask 0 leaves remainder
      do_seed(32'h0BAD_CAFE);
      issue_acc(32'hFFFF_FFFF, 4'h0); wait_idle();
      do_read(v, ok);
      check("R4 empty mask", v, 32'h0BAD_CAFE);

      // R5 busy window length
      do_seed(32'h1111_2222);
      issue_acc(32'h5555_AAAA, 4'hF);
      n = 0;
      while (busy && n < 100) begin n++; @(negedge clk); end
      check("R5 busy cycles", n, 14);

      // R6 accumulate while busy refused
      do_seed(32'h2468_ACE0);
      issue_acc(32'h1357_9BDF, 4'hF);
      acc_req = 1'b1; acc_data = 32'hFFFF_0000; acc_be = 4'hF;
      repeat (3) @(negedge clk);
      acc_req = 1'b0;
      wait_idle();
      do_read(v, ok);
      check("R6 refused acc", v, ref_crc(32'h2468_ACE0, 32'h1357_9BDF, 4'hF));

      // R7 seed while busy refused
      do_seed(32'h0F0F_0F0F);
      issue_acc(32'h89AB_CDEF, 4'hC);
      seed_we = 1'b1; seed_data = 32'h0000_0000;
      @(negedge clk); seed_we = 1'b0;
      wait_idle();
      do_read(v, ok);
      check("R7 refused seed", v, ref_crc(32'h0F0F_0F0F, 32'h89AB_CDEF, 4'hC));

      // R2 seed wins over same-cycle accumulate
      @(negedge clk);
      seed_we = 1'b1; seed_data = 32'h7E57_0001;
      acc_req = 1'b1; acc_data = 32'h1234_0000; acc_be = 4'hF;
      @(negedge clk);
      seed_we = 1'b0; acc_req = 1'b0;
      check("R2 acc refused", {31'd0, busy}, 32'd0);
      do_read(v, ok);
      check("R2 seed loaded", v, 32'h7E57_0001);

      // R8 read same cycle as seed sees new seed
      @(negedge clk); seed_we = 1'b1; seed_data = 32'h3C3C_C3C3; rd_req = 1'b1;
      @(negedge clk); seed_we = 1'b0; rd_req = 1'b0;
      check("R8 same-cycle seed", rd_data, 32'h3C3C_C3C3);

      // R9 read while busy held until completion
      exp = ref_crc(32'h3C3C_C3C3, 32'h0A0B_0C0D, 4'hF);
      issue_acc(32'h0A0B_0C0D, 4'hF);
      rd_req = 1'b1;
      @(negedge clk); rd_req = 1'b0;
      n = 0;
      while (!rd_valid && n < 100) begin @(negedge clk); n++; end
      check("R9 held read delay", n, 13);
      check("R9 held read busy", {31'd0, busy}, 32'd0);
      check("R9 held read data", rd_data, exp);

      // R9 read in same cycle as accepted accumulate
      @(negedge clk);
      acc_req = 1'b1; acc_data = 32'hFEDC_BA98; acc_be = 4'h3; rd_req = 1'b1;
      @(negedge clk); acc_req = 1'b0; rd_req = 1'b0;
      check("R9 no early answer", {31'd0, rd_valid}, 32'd0);
      n = 0;
      while (!rd_valid && n < 100) begin @(negedge clk); n++; end
      check("R9 same-cycle read data", rd_data, ref_crc(exp, 32'hFEDC_BA98, 4'h3));

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule